// File: doc/BRIEF.md
# Dual-Bank Register File

This block is the general-purpose register storage of a small 16-bit processor core. It holds sixteen 16-bit registers in a primary bank and an identical alternate bank. Two read ports and one write port always address whichever bank is currently selected. A one-cycle swap command changes the selection. An interrupt handler can therefore get a clean working set and give it back without saving any register to memory.

The swap does not copy any data. It inverts a single bank-select flop, and the `alt_active` output reports that flop to the rest of the core. Writes take effect on the rising clock edge. Reads are combinational and show the state held before that edge, so a register that is read in the cycle it is written still returns its previous contents. The logic that decodes the exchange instruction and sequences interrupt entry lives outside this block.

Top module: `dualbank_regfile`

## Requirements
- R1: A synchronous reset (`srst` high at a rising edge) sets every register in both banks to zero and selects the primary bank (`alt_active` = 0).
- R2: When `wr_en` is high at a rising edge, `wr_data` is stored in register `wr_addr` of the bank that is selected during that cycle. The new value can be read from the next cycle onward.
- R3: When `wr_en` is low at a rising edge, no register in either bank changes.
- R4: Both read ports are combinational and independent. Each returns the register at its own address in the selected bank, within the same cycle as the address is presented.
- R5: A rising edge with `swap_bank` high inverts `alt_active`, so a second swap returns to the primary bank. The encoding is 0 for the primary bank and 1 for the alternate bank. With `swap_bank` low, `alt_active` holds its value.
- R6: The two banks are separate storage. A write to one bank never changes what the other bank returns after a swap.
- R7: When a write and a swap happen at the same edge, the data lands in the bank that was selected before the swap.
- R8: A read of the register being written in the same cycle returns the old value. There is no write-through bypass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| srst | input | 1 | Synchronous reset, active high |
| rd_addr_a | input | 4 | Read port A register index |
| rd_data_a | output | 16 | Read port A data from the selected bank |
| rd_addr_b | input | 4 | Read port B register index |
| rd_data_b | output | 16 | Read port B data from the selected bank |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 4 | Write register index |
| wr_data | input | 16 | Write data |
| swap_bank | input | 1 | Invert the bank selection at this edge |
| alt_active | output | 1 | 0 = primary bank selected, 1 = alternate bank selected |

## Verification
If the bank-select flop goes wrong, `alt_active` is wrong one edge after the swap. Every following read then returns the other bank's contents, and a write steered to the wrong bank only shows up after a later swap brings that bank back into view. A corrupt register shows on a read port in the same cycle its address is presented. The bench keeps a model of both banks and compares both ports on every cycle, before each edge. It also performs swaps often enough that a wrongly steered write is exposed within a few cycles.

// File: rtl/dualbank_regfile_pkg.sv
package dualbank_regfile_pkg;

    localparam int NUM_BANKS    = 2;
    localparam int NUM_RD_PORTS = 2;

    typedef enum logic {
        BANK_MAIN = 1'b0,
        BANK_ALT  = 1'b1
    } bank_sel_e;

endpackage

// File: rtl/rf_bank_select.sv
module rf_bank_select
    import dualbank_regfile_pkg::*;
(
    input  logic      clk,
    input  logic      srst,
    input  logic      swap,
    output bank_sel_e bank
);

    typedef struct packed {
        bank_sel_e bank;
    } sel_state_t;

    sel_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (srst) begin
            state_d.bank = BANK_MAIN;
        end else if (swap) begin
            state_d.bank = (state_q.bank == BANK_MAIN) ? BANK_ALT : BANK_MAIN;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign bank = state_q.bank;

endmodule

// File: rtl/rf_bank_array.sv
module rf_bank_array #(
    parameter  int DATA_W    = 16,
    parameter  int REG_COUNT = 16,
    parameter  int RD_PORTS  = 2,
    localparam int ADDR_W    = $clog2(REG_COUNT)
) (
    input  logic                              clk,
    input  logic                              clr,
    input  logic                              we,
    input  logic [ADDR_W-1:0]                 waddr,
    input  logic [DATA_W-1:0]                 wdata,
    input  logic [RD_PORTS-1:0][ADDR_W-1:0]   raddr,
    output logic [RD_PORTS-1:0][DATA_W-1:0]   rdata
);

    typedef struct packed {
        logic [REG_COUNT-1:0][DATA_W-1:0] regs;
    } bank_state_t;

    bank_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d.regs = '0;
        end else if (we) begin
            state_d.regs[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        assign rdata[p] = state_q.regs[raddr[p]];
    end

endmodule

// File: rtl/rf_read_mux.sv
module rf_read_mux
    import dualbank_regfile_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  bank_sel_e            sel,
    input  logic [DATA_W-1:0]    main_data,
    input  logic [DATA_W-1:0]    alt_data,
    output logic [DATA_W-1:0]    data
);

    always_comb begin
        data = (sel == BANK_ALT) ? alt_data : main_data;
    end

endmodule

// File: rtl/dualbank_regfile.sv
module dualbank_regfile
    import dualbank_regfile_pkg::*;
#(
    parameter  int DATA_W    = 16,
    parameter  int REG_COUNT = 16,
    localparam int ADDR_W    = $clog2(REG_COUNT)
) (
    input  logic              clk,
    input  logic              srst,
    input  logic [ADDR_W-1:0] rd_addr_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic [DATA_W-1:0] rd_data_b,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              swap_bank,
    output logic              alt_active
);

    bank_sel_e                                        cur_bank;
    logic [NUM_RD_PORTS-1:0][ADDR_W-1:0]              rd_addr;
    logic [NUM_RD_PORTS-1:0][DATA_W-1:0]              rd_data;
    logic [NUM_BANKS-1:0][NUM_RD_PORTS-1:0][DATA_W-1:0] bank_rdata;

    assign rd_addr[0] = rd_addr_a;
    assign rd_addr[1] = rd_addr_b;

    rf_bank_select u_sel (
        .clk  (clk),
        .srst (srst),
        .swap (swap_bank),
        .bank (cur_bank)
    );

    // Write steering uses the selection held before the edge, so a write
    // issued together with a swap lands in the outgoing bank.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic bank_we;
        assign bank_we = wr_en && (cur_bank == bank_sel_e'(b));

        rf_bank_array #(
            .DATA_W    (DATA_W),
            .REG_COUNT (REG_COUNT),
            .RD_PORTS  (NUM_RD_PORTS)
        ) u_bank (
            .clk   (clk),
            .clr   (srst),
            .we    (bank_we),
            .waddr (wr_addr),
            .wdata (wr_data),
            .raddr (rd_addr),
            .rdata (bank_rdata[b])
        );
    end

    for (genvar p = 0; p < NUM_RD_PORTS; p++) begin : g_port
        rf_read_mux #(
            .DATA_W (DATA_W)
        ) u_mux (
            .sel       (cur_bank),
            .main_data (bank_rdata[0][p]),
            .alt_data  (bank_rdata[1][p]),
            .data      (rd_data[p])
        );
    end

    assign rd_data_a  = rd_data[0];
    assign rd_data_b  = rd_data[1];
    assign alt_active = (cur_bank == BANK_ALT);

endmodule

// File: rtl/dualbank_regfile_checker.sv
module dualbank_regfile_checker #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              srst,
    input logic [ADDR_W-1:0] rd_addr_a,
    input logic [DATA_W-1:0] rd_data_a,
    input logic [ADDR_W-1:0] rd_addr_b,
    input logic [DATA_W-1:0] rd_data_b,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              swap_bank,
    input logic              alt_active
);

    // R1
    a_r1_reset_primary: assert property (@(posedge clk)
        srst |=> !alt_active);

    // R5
    a_r5_swap_toggles: assert property (@(posedge clk) disable iff (srst)
        swap_bank |=> (alt_active != $past(alt_active)));

    // R5
    a_r5_select_holds: assert property (@(posedge clk) disable iff (srst)
        !swap_bank |=> $stable(alt_active));

    // R2
    a_r2_write_lands: assert property (@(posedge clk) disable iff (srst)
        ($past(wr_en) && !$past(swap_bank) && !$past(srst) &&
         rd_addr_a == $past(wr_addr)) |-> (rd_data_a == $past(wr_data)));

    // R3
    a_r3_no_write_stable: assert property (@(posedge clk) disable iff (srst)
        (!$past(wr_en) && !$past(swap_bank) && !$past(srst) &&
         rd_addr_b == $past(rd_addr_b)) |-> (rd_data_b == $past(rd_data_b)));

    // R4
    a_r4_ports_agree: assert property (@(posedge clk) disable iff (srst)
        (rd_addr_a == rd_addr_b) |-> (rd_data_a == rd_data_b));

endmodule

bind dualbank_regfile dualbank_regfile_checker #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .srst       (srst),
    .rd_addr_a  (rd_addr_a),
    .rd_data_a  (rd_data_a),
    .rd_addr_b  (rd_addr_b),
    .rd_data_b  (rd_data_b),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .swap_bank  (swap_bank),
    .alt_active (alt_active)
);

// File: tb/dualbank_regfile_test.sv
`timescale 1ns/1ps
module dualbank_regfile_test;

    localparam int DW = 16;
    localparam int NR = 16;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          srst;
    logic [AW-1:0] rd_addr_a, rd_addr_b, wr_addr;
    logic [DW-1:0] rd_data_a, rd_data_b, wr_data;
    logic          wr_en, swap_bank, alt_active;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [DW-1:0] model [2][NR];
    int            mbank;

    always #2 clk = ~clk;

    dualbank_regfile uut (
        .clk        (clk),
        .srst       (srst),
        .rd_addr_a  (rd_addr_a),
        .rd_data_a  (rd_data_a),
        .rd_addr_b  (rd_addr_b),
        .rd_data_b  (rd_data_b),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .swap_bank  (swap_bank),
        .alt_active (alt_active)
    );

    function automatic logic [DW-1:0] expect_rd(input logic [AW-1:0] a);
        return model[mbank][a];
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_ports(input string req);
        check(req, rd_data_a, expect_rd(rd_addr_a));
        check(req, rd_data_b, expect_rd(rd_addr_b));
        check("R5", {15'd0, alt_active}, DW'(mbank));
    endtask

    // Drive at negedge, check before the edge, then update the model at the edge.
    task automatic step(input logic we, input logic [AW-1:0] wa,
                        input logic [DW-1:0] wd, input logic sw,
                        input logic [AW-1:0] ra, input logic [AW-1:0] rb,
                        input string req);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd; swap_bank = sw;
        rd_addr_a = ra; rd_addr_b = rb;
        #1;
        check_ports(req);
        @(posedge clk);
        if (we) model[mbank][wa] = wd;   // R7: pre-swap bank
        if (sw) mbank = 1 - mbank;
    endtask

    task automatic do_reset();
        @(negedge clk);
        srst = 1'b1; wr_en = 1'b0; swap_bank = 1'b0;
        @(posedge clk);
        @(negedge clk);
        srst = 1'b0;
        for (int b = 0; b < 2; b++)
            for (int r = 0; r < NR; r++) model[b][r] = '0;
        mbank = 0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        srst = 1'b1; wr_en = 1'b0; swap_bank = 1'b0;
        wr_addr = '0; wr_data = '0; rd_addr_a = '0; rd_addr_b = '0;
        mbank = 0;
        repeat (2) @(posedge clk);
        do_reset();

        // R1: every register of both banks reads zero after reset
        for (int r = 0; r < NR; r++)
            step(1'b0, '0, '0, (r == NR - 1), AW'(r), AW'(NR - 1 - r), "R1");
        for (int r = 0; r < NR; r++)
            step(1'b0, '0, '0, (r == NR - 1), AW'(r), AW'(r), "R1");

        // R2 and R8: write, read the same register in that cycle (old value), then new
        step(1'b1, 4'd3, 16'hBEEF, 1'b0, 4'd3, 4'd3, "R8");
        step(1'b0, 4'd0, 16'h0000, 1'b0, 4'd3, 4'd0, "R2");

        // R6: write in the alternate bank, primary copy unaffected
        step(1'b0, 4'd0, 16'h0, 1'b1, 4'd3, 4'd3, "R5");
        step(1'b1, 4'd3, 16'h1234, 1'b0, 4'd3, 4'd3, "R6");
        step(1'b0, 4'd0, 16'h0, 1'b1, 4'd3, 4'd3, "R6");
        step(1'b0, 4'd0, 16'h0, 1'b0, 4'd3, 4'd3, "R6");

        // R7: write together with swap lands in outgoing (primary) bank
        step(1'b1, 4'd9, 16'hA5A5, 1'b1, 4'd9, 4'd9, "R7");
        step(1'b0, 4'd0, 16'h0, 1'b1, 4'd9, 4'd9, "R7");
        step(1'b0, 4'd0, 16'h0, 1'b0, 4'd9, 4'd15, "R7");

        // R3: wr_en low with data/address toggling changes nothing
        step(1'b0, 4'd9, 16'hFFFF, 1'b0, 4'd9, 4'd3, "R3");
        step(1'b0, 4'd3, 16'h7777, 1'b0, 4'd9, 4'd3, "R3");

        // Random traffic: R4 both ports every cycle, swaps mixed in
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 3) != 0, AW'($urandom), DW'($urandom),
                 ($urandom % 5) == 0, AW'($urandom), AW'($urandom), "R4");
        end

        // R1: reset in the alternate bank returns to primary with zeros
        if (mbank == 0) step(1'b0, '0, '0, 1'b1, 4'd0, 4'd0, "R5");
        do_reset();
        for (int r = 0; r < NR; r++)
            step(1'b0, '0, '0, 1'b0, AW'(r), AW'(r), "R1");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule